// File: doc/BRIEF.md
# Serial NAND Page Program and Block Erase Sequencer

This block runs the byte-level command sequences that write one page to, or erase one block of, a serial NAND flash device. It then watches the device status until the operation ends. A single `start_i` pulse selects the operation, the 24-bit row address and the geometry flags. The block then hands bytes, one at a time, to an external SPI shifter. Each byte carries a last-of-frame flag, and the shifter deasserts chip select after that byte. The shifter returns the byte it clocked in on the same handshake.

For a program, the page payload is fetched from an external synchronous page buffer. The buffer returns data one cycle after a read request. The block ends each operation with a one-cycle done pulse and a 2-bit result code. The code is held until the next operation starts.

Top module: `nand_pe_seq`

## Requirements
- R1: Every program and every erase begins with a frame holding the single byte 0x06.
- R2: An erase sends one frame of four bytes: 0xD8, then row bits 23:16, 15:8 and 7:0.
- R3: A program sends a load frame. It starts with 0x02, or 0x32 when `quad_i` is high, and then two column bytes. The page payload follows as `(sec8_i ? 8 : 4) * SECTOR_BYTES` bytes, read from buffer addresses 0 upward in order. A byte offered to the shifter stays unchanged until it is accepted.
- R4: The load column is 0 when `two_plane_i` is low. When `two_plane_i` is high, column bit 12 equals row bit 6 and all other column bits are 0. The column is sent high byte first.
- R5: After the load frame, a program sends an execute frame of four bytes: 0x10 and the three row bytes, high byte first.
- R6: After the erase frame or the execute frame, the block sends status poll frames of 0x0F, 0xC0, 0x00. It repeats them while status bit 0 (busy), received with the third byte, reads 1.
- R7: Once bit 0 reads 0, the result is 1 (fail) if status bit 2 is set after an erase, or if status bit 3 is set after a program. Otherwise the result is 0 (pass). The other fail bit, and any fail bits seen while busy, are ignored.
- R8: If POLL_MAX consecutive polls read busy, the result is 2 (timeout) and no further frame is sent. A ready status on poll number POLL_MAX still yields pass or fail.
- R9: `done_o` is high for exactly one cycle per operation. `busy_o` is high in every cycle from the cycle after `start_i` is taken until `done_o` rises, and low while `done_o` is high.
- R10: A `start_i` pulse that arrives while `busy_o` is high is ignored. It changes neither the current operation nor its bytes, and it starts nothing afterwards.
- R11: While reset is asserted, and right after it is released, `busy_o`, `done_o`, `spi_valid_o` and `buf_rd_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| erase_i | input | 1 | 1 = block erase, 0 = page program |
| row_i | input | 24 | Row (page) address |
| two_plane_i | input | 1 | Device has two planes |
| quad_i | input | 1 | Use the four-lane load opcode |
| sec8_i | input | 1 | Page holds 8 sectors (else 4) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 pass, 1 fail, 2 timeout |
| spi_valid_o | output | 1 | Byte offered to the shifter |
| spi_byte_o | output | 8 | Byte to shift out |
| spi_last_o | output | 1 | Byte closes its chip-select frame |
| spi_ready_i | input | 1 | Shifter accepts the byte |
| spi_rx_i | input | 8 | Byte shifted in during the accepted byte |
| buf_rd_o | output | 1 | Page buffer read request |
| buf_addr_o | output | $clog2(8*SECTOR_BYTES) | Page buffer byte address |
| buf_data_i | input | 8 | Page buffer data, one cycle after the request |

## Verification
The bench builds the block with SECTOR_BYTES = 16 and POLL_MAX = 5. The short payload (64 or 128 bytes) lets every byte of every frame be compared against an expected stream. The small poll limit puts both sides of the timeout boundary within reach: four busy reads followed by ready, and five or more busy reads. The busy status used in the bench also carries both fail bits, which shows that they are ignored until bit 0 clears.

// File: rtl/nand_pe_pkg.sv
package nand_pe_pkg;
  typedef enum logic [2:0] {PH_WREN, PH_LOAD, PH_ERASE, PH_EXEC, PH_POLL} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_FETCH, ST_SEND} state_e;
  typedef enum logic [1:0] {RES_PASS = 2'd0, RES_FAIL = 2'd1, RES_TIMEOUT = 2'd2} result_e;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_LOAD_X1 = 8'h02;
  localparam logic [7:0] OP_LOAD_X4 = 8'h32;
  localparam logic [7:0] OP_EXEC    = 8'h10;
  localparam logic [7:0] OP_ERASE   = 8'hD8;
  localparam logic [7:0] OP_GETF    = 8'h0F;
  localparam logic [7:0] REG_STATUS = 8'hC0;

  localparam int PLANE_ROW_BIT = 6;
  localparam int PLANE_COL_BIT = 12;
endpackage

// File: rtl/nand_pe_hdr.sv
module nand_pe_hdr
  import nand_pe_pkg::*;
(
  input  phase_e      phase_i,
  input  logic [1:0]  idx_i,
  input  logic [23:0] row_i,
  input  logic        two_plane_i,
  input  logic        quad_i,
  output logic [7:0]  hdr_o
);
  logic [15:0] col;
  logic [7:0]  row_byte;

  assign col = two_plane_i ? (16'(row_i[PLANE_ROW_BIT]) << PLANE_COL_BIT) : 16'h0000;

  always_comb begin
    unique case (idx_i)
      2'd1:    row_byte = row_i[23:16];
      2'd2:    row_byte = row_i[15:8];
      default: row_byte = row_i[7:0];
    endcase
  end

  always_comb begin
    hdr_o = 8'h00;
    unique case (phase_i)
      PH_WREN:  hdr_o = OP_WREN;
      PH_LOAD:  hdr_o = (idx_i == 2'd0) ? (quad_i ? OP_LOAD_X4 : OP_LOAD_X1)
                      : (idx_i == 2'd1) ? col[15:8] : col[7:0];
      PH_ERASE: hdr_o = (idx_i == 2'd0) ? OP_ERASE : row_byte;
      PH_EXEC:  hdr_o = (idx_i == 2'd0) ? OP_EXEC : row_byte;
      PH_POLL:  hdr_o = (idx_i == 2'd0) ? OP_GETF : (idx_i == 2'd1) ? REG_STATUS : 8'h00;
      default:  hdr_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/nand_pe_poll.sv
module nand_pe_poll
  import nand_pe_pkg::*;
#(
  parameter int POLL_MAX = 100000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clr_i,
  input  logic    eval_i,
  input  logic    erase_i,
  input  logic    busy_bit_i,
  input  logic    efail_bit_i,
  input  logic    pfail_bit_i,
  output logic    verdict_o,
  output result_e code_o
);
  localparam int CW = $clog2(POLL_MAX + 1);
  localparam logic [CW-1:0] LIM = CW'(POLL_MAX - 1);

  logic [CW-1:0] cnt_q;
  logic          at_lim;

  assign at_lim    = (cnt_q == LIM);
  assign verdict_o = eval_i && (!busy_bit_i || at_lim);

  always_comb begin
    if (busy_bit_i) code_o = RES_TIMEOUT;
    else if (erase_i ? efail_bit_i : pfail_bit_i) code_o = RES_FAIL;
    else code_o = RES_PASS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (eval_i && busy_bit_i && !at_lim) cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(POLL_MAX));
  // R7: while busy the verdict can only be a timeout
  assert_busy_no_fail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_o && busy_bit_i |-> code_o == RES_TIMEOUT);
endmodule

// File: rtl/nand_pe_seq.sv
module nand_pe_seq
  import nand_pe_pkg::*;
#(
  parameter int SECTOR_BYTES = 528,
  parameter int POLL_MAX     = 100000,
  localparam int DATA_MAX    = 8 * SECTOR_BYTES,
  localparam int ADDR_W      = $clog2(DATA_MAX),
  localparam int IDX_W       = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [23:0]       row_i,
  input  logic              two_plane_i,
  input  logic              quad_i,
  input  logic              sec8_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic              spi_valid_o,
  output logic [7:0]        spi_byte_o,
  output logic              spi_last_o,
  input  logic              spi_ready_i,
  input  logic [7:0]        spi_rx_i,
  output logic              buf_rd_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_data_i
);
  localparam logic [IDX_W-1:0] LAST4 = IDX_W'(4 * SECTOR_BYTES + 2);
  localparam logic [IDX_W-1:0] LAST8 = IDX_W'(8 * SECTOR_BYTES + 2);

  state_e           state_q;
  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       tx_q;
  logic             done_q;
  result_e          result_q;
  logic             erase_q, two_plane_q, quad_q, sec8_q;
  logic [23:0]      row_q;

  logic             accept, is_data, frame_end, hs, eval, verdict;
  logic [7:0]       hdr;
  logic [IDX_W-1:0] data_off;
  result_e          code;
  logic             unused_rx;
  logic             unused_off_msb;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign is_data   = (phase_q == PH_LOAD) && (idx_q >= IDX_W'(3));
  assign data_off  = idx_q - IDX_W'(3);
  assign hs        = (state_q == ST_SEND) && spi_ready_i;
  assign eval      = hs && frame_end && (phase_q == PH_POLL);
  assign unused_rx = ^{spi_rx_i[7:4], spi_rx_i[1]};
  assign unused_off_msb = data_off[IDX_W-1];

  always_comb begin
    unique case (phase_q)
      PH_WREN:           frame_end = (idx_q == '0);
      PH_LOAD:           frame_end = (idx_q == (sec8_q ? LAST8 : LAST4));
      PH_ERASE, PH_EXEC: frame_end = (idx_q == IDX_W'(3));
      PH_POLL:           frame_end = (idx_q == IDX_W'(2));
      default:           frame_end = 1'b1;
    endcase
  end

  nand_pe_hdr i_hdr (
    .phase_i     (phase_q),
    .idx_i       (idx_q[1:0]),
    .row_i       (row_q),
    .two_plane_i (two_plane_q),
    .quad_i      (quad_q),
    .hdr_o       (hdr)
  );

  nand_pe_poll #(.POLL_MAX(POLL_MAX)) i_poll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .eval_i      (eval),
    .erase_i     (erase_q),
    .busy_bit_i  (spi_rx_i[0]),
    .efail_bit_i (spi_rx_i[2]),
    .pfail_bit_i (spi_rx_i[3]),
    .verdict_o   (verdict),
    .code_o      (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_WREN;
      idx_q       <= '0;
      tx_q        <= '0;
      done_q      <= 1'b0;
      result_q    <= RES_PASS;
      erase_q     <= 1'b0;
      two_plane_q <= 1'b0;
      quad_q      <= 1'b0;
      sec8_q      <= 1'b0;
      row_q       <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          erase_q     <= erase_i;
          row_q       <= row_i;
          two_plane_q <= two_plane_i;
          quad_q      <= quad_i;
          sec8_q      <= sec8_i;
          phase_q     <= PH_WREN;
          idx_q       <= '0;
          state_q     <= ST_LOAD;
        end
        ST_LOAD: if (is_data) state_q <= ST_FETCH;
                 else begin tx_q <= hdr; state_q <= ST_SEND; end
        ST_FETCH: begin tx_q <= buf_data_i; state_q <= ST_SEND; end
        ST_SEND: if (spi_ready_i) begin
          if (!frame_end) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_LOAD;
          end else begin
            idx_q   <= '0;
            state_q <= ST_LOAD;
            unique case (phase_q)
              PH_WREN:           phase_q <= erase_q ? PH_ERASE : PH_LOAD;
              PH_LOAD:           phase_q <= PH_EXEC;
              PH_ERASE, PH_EXEC: phase_q <= PH_POLL;
              default: if (verdict) begin
                result_q <= code;
                done_q   <= 1'b1;
                state_q  <= ST_IDLE;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign result_o    = result_q;
  assign spi_valid_o = (state_q == ST_SEND);
  assign spi_byte_o  = tx_q;
  assign spi_last_o  = frame_end;
  assign buf_rd_o    = (state_q == ST_LOAD) && is_data;
  assign buf_addr_o  = data_off[ADDR_W-1:0];

  assert_tx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_valid_o && !spi_ready_i |=> spi_valid_o && $stable(spi_byte_o) && $stable(spi_last_o));
  assert_buf_rd_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_o |-> !erase_q && phase_q == PH_LOAD);
  assert_wren_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_valid_o && phase_q == PH_WREN |-> spi_last_o && spi_byte_o == OP_WREN);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(row_q) && $stable(erase_q) && $stable(sec8_q));
endmodule

// File: tb/test_nand_pe_seq.sv
module test_nand_pe_seq;
  localparam int CLK_P    = 10;
  localparam int SB       = 16;
  localparam int PMAX     = 5;
  localparam int AW       = $clog2(8 * SB);
  localparam int WDOG_CYC = 60000;

  typedef struct packed {
    logic        er;
    logic [23:0] row;
    logic        tp;
    logic        qd;
    logic        s8;
    logic [3:0]  nbusy;
    logic [7:0]  fst;
    logic [1:0]  res;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b0, 24'h012345, 1'b1, 1'b0, 1'b0, 4'd2, 8'h00, 2'd0},
    '{1'b0, 24'h000080, 1'b1, 1'b1, 1'b1, 4'd0, 8'h08, 2'd1},
    '{1'b0, 24'h3FFFC0, 1'b0, 1'b0, 1'b1, 4'd1, 8'h04, 2'd0},
    '{1'b1, 24'hABCD40, 1'b0, 1'b0, 1'b0, 4'd3, 8'h04, 2'd1},
    '{1'b1, 24'h000100, 1'b1, 1'b1, 1'b1, 4'd0, 8'h08, 2'd0},
    '{1'b1, 24'h123456, 1'b0, 1'b0, 1'b0, 4'd9, 8'h00, 2'd2},
    '{1'b0, 24'h000040, 1'b1, 1'b1, 1'b0, 4'd4, 8'h0C, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, erase_i = 1'b0, two_plane_i = 1'b0, quad_i = 1'b0, sec8_i = 1'b0;
  logic [23:0] row_i = '0;
  logic busy_o, done_o, spi_valid_o, spi_last_o, buf_rd_o;
  logic [1:0] result_o;
  logic [7:0] spi_byte_o;
  logic spi_ready_i = 1'b0;
  logic [7:0] spi_rx_i = '0;
  logic [AW-1:0] buf_addr_o;
  logic [7:0] buf_data_i = '0;

  always #(CLK_P / 2) clk = ~clk;

  nand_pe_seq #(.SECTOR_BYTES(SB), .POLL_MAX(PMAX)) i_nand_pe_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .erase_i(erase_i), .row_i(row_i),
    .two_plane_i(two_plane_i), .quad_i(quad_i), .sec8_i(sec8_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .spi_valid_o(spi_valid_o), .spi_byte_o(spi_byte_o), .spi_last_o(spi_last_o),
    .spi_ready_i(spi_ready_i), .spi_rx_i(spi_rx_i),
    .buf_rd_o(buf_rd_o), .buf_addr_o(buf_addr_o), .buf_data_i(buf_data_i)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [7:0] cap_b [256];
  logic       cap_l [256];
  int         cap_n;
  logic [7:0] exp_b [256];
  logic       exp_l [256];
  string      exp_t [256];
  int         exp_n;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_CYC) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cycles, WDOG_CYC);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic push(input logic [7:0] b, input logic l, input string t);
    exp_b[exp_n] = b; exp_l[exp_n] = l; exp_t[exp_n] = t; exp_n++;
  endtask

  task automatic build(input vec_t v, input int npolls);
    logic [15:0] col;
    int len;
    exp_n = 0;
    push(8'h06, 1'b1, "R1");
    if (v.er) begin
      push(8'hD8, 1'b0, "R2"); push(v.row[23:16], 1'b0, "R2");
      push(v.row[15:8], 1'b0, "R2"); push(v.row[7:0], 1'b1, "R2");
    end else begin
      col = v.tp ? {3'b000, v.row[6], 12'h000} : 16'h0000;
      len = (v.s8 ? 8 : 4) * SB;
      push(v.qd ? 8'h32 : 8'h02, 1'b0, "R3");
      push(col[15:8], 1'b0, "R4"); push(col[7:0], 1'b0, "R4");
      for (int k = 0; k < len; k++) push(8'((k * 7 + 3) & 255), k == len - 1, "R3");
      push(8'h10, 1'b0, "R5"); push(v.row[23:16], 1'b0, "R5");
      push(v.row[15:8], 1'b0, "R5"); push(v.row[7:0], 1'b1, "R5");
    end
    for (int p = 0; p < npolls; p++) begin
      push(8'h0F, 1'b0, "R6"); push(8'hC0, 1'b0, "R6"); push(8'h00, 1'b1, "R6");
    end
  endtask

  task automatic compare_stream();
    string tags [6] = '{"R1", "R2", "R3", "R4", "R5", "R6"};
    chk(cap_n == exp_n, "R6", "byte count", cap_n, exp_n);
    foreach (tags[t]) begin
      bit present = 0, ok = 1;
      int bad_i = 0;
      for (int i = 0; i < exp_n; i++) if (exp_t[i] == tags[t]) begin
        present = 1;
        if (ok && (i >= cap_n || cap_b[i] != exp_b[i] || cap_l[i] != exp_l[i])) begin
          ok = 0; bad_i = i;
        end
      end
      if (present)
        chk(ok, tags[t], $sformatf("byte/last at %0d", bad_i),
            (bad_i < cap_n) ? {cap_l[bad_i], cap_b[bad_i]} : -1, {exp_l[bad_i], exp_b[bad_i]});
    end
  endtask

  task automatic run_op(input vec_t v, input int poke);
    int cyc = 0, fpos = 0, seen = 0, npolls;
    logic [7:0] fop = 8'h00;
    bit done_seen = 0, busy_bad = 0, busy_at_done = 0, pend = 0;
    logic [AW-1:0] paddr = '0;
    logic [1:0] res = '0;
    npolls = (int'(v.nbusy) >= PMAX) ? PMAX : int'(v.nbusy) + 1;
    build(v, npolls);
    cap_n = 0;
    @(negedge clk);
    erase_i = v.er; row_i = v.row; two_plane_i = v.tp; quad_i = v.qd; sec8_i = v.s8;
    start_i = 1'b1;
    while (!done_seen && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start_i = (cyc == poke);
      if (cyc == poke) begin row_i = 24'hFFFFFF; erase_i = ~v.er; sec8_i = ~v.s8; end
      if (pend) buf_data_i = 8'((int'(paddr) * 7 + 3) & 255);
      pend = buf_rd_o; paddr = buf_addr_o;
      if (spi_valid_o && !spi_ready_i) begin
        spi_ready_i = 1'b1;
        if (cap_n < 256) begin cap_b[cap_n] = spi_byte_o; cap_l[cap_n] = spi_last_o; cap_n++; end
        if (fpos == 0) fop = spi_byte_o;
        if (fop == 8'h0F && fpos == 2) begin
          spi_rx_i = (seen < int'(v.nbusy)) ? 8'h0D : v.fst;
          seen++;
        end else spi_rx_i = 8'hA5;
        fpos = spi_last_o ? 0 : fpos + 1;
      end else spi_ready_i = 1'b0;
      if (done_o) begin done_seen = 1; res = result_o; busy_at_done = busy_o; end
      else if (!busy_o) busy_bad = 1;
    end
    start_i = 1'b0;
    spi_ready_i = 1'b0;
    chk(done_seen, "R9", "done seen", done_seen, 1);
    chk(!busy_bad, "R9", "busy held until done", busy_bad, 0);
    chk(!busy_at_done, "R9", "busy low at done", busy_at_done, 0);
    chk(res == v.res, (v.res == 2'd2) ? "R8" : "R7", "result", res, v.res);
    compare_stream();
    @(negedge clk);
    chk(!done_o, "R9", "done one cycle", done_o, 0);
    chk(result_o == v.res, "R7", "result held", result_o, v.res);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (poke >= 0) chk(!busy_o && !spi_valid_o, "R10", "no op after ignored start",
                         {busy_o, spi_valid_o}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs idle under reset and just after release
    chk(!busy_o && !done_o && !spi_valid_o && !buf_rd_o && result_o == 2'd0, "R11",
        "state in reset", {busy_o, done_o, spi_valid_o, buf_rd_o, result_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !spi_valid_o && !buf_rd_o && result_o == 2'd0, "R11",
        "state after reset", {busy_o, done_o, spi_valid_o, buf_rd_o, result_o}, 0);

    foreach (VEC[i]) run_op(VEC[i], -1);

    // R10: start poked mid-erase with a different row and op
    run_op('{1'b1, 24'h0A0B0C, 1'b0, 1'b0, 1'b0, 4'd1, 8'h00, 2'd0}, 3);
    chk(cap_n == exp_n && cap_b[2] == 8'h0A && cap_b[4] == 8'h0C, "R10",
        "stream kept original row", {cap_b[2], cap_b[4]}, 16'h0A0C);

    // R11: reset in the middle of a program returns to idle
    @(negedge clk);
    erase_i = 1'b0; row_i = 24'h000001; sec8_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(!busy_o && !spi_valid_o && !buf_rd_o && !done_o, "R11", "reset mid op",
        {busy_o, spi_valid_o, buf_rd_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && result_o == 2'd0, "R11", "idle after mid-op reset", {busy_o, result_o}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule